// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the two source register numbers of the instruction sitting in decode. It compares them against the pending writes held in the execute, memory and writeback pipeline registers. From that it drives the select lines of the two operand forwarding multiplexers, so that a result not yet written back reaches the operand latches without passing through the register file.

It also spots the one case forwarding cannot cover: a load in execute whose destination the decode instruction reads. It then raises a freeze for fetch and decode and asks for a bubble, meaning a cleared valid bit, in execute. A store whose data register (rt) is the only operand fed by that load is not stalled. Its data is instead replaced one stage later by a memory-stage bypass, which this block also signals. All outputs are combinational from the present pipeline register contents. There is no state.

Top module: `hz_ctrl`

## Requirements
- R1: A stage counts as a pending write for a source operand only when its valid bit and its write-enable are both 1 and its destination number equals the source number.
- R2: Each forwarding select is 2 bits: 00 register file, 01 execute result, 10 memory-stage result, 11 writeback value; with no pending match the select is 00.
- R3: When several stages match the same operand, the nearest wins: execute over memory over writeback.
- R4: A stage whose valid bit is 0 never produces a match, a stall or a store bypass, whatever its other fields hold.
- R5: Source register 0 never matches any stage, for forwarding or for stalling.
- R6: When execute holds a valid, write-enabled load whose destination matches decode rs, or matches decode rt, then `stall` and `bubble` are both 1. Otherwise both are 0, except as R7 allows.
- R7: If decode holds a store (`dec_is_store`=1) and the execute load matches only its rt, `stall` and `bubble` stay 0; a match on rs still stalls.
- R8: `st_bypass` is 1 exactly when memory holds a valid store, writeback holds a valid write-enabled load, and the load's destination equals the store's data register `mem_st_rt`, which is nonzero.
- R9: Every output follows its inputs within the same cycle, with no clock or register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | AW | First source register of the decode instruction |
| dec_rt | input | AW | Second source register of the decode instruction |
| dec_is_store | input | 1 | Decode instruction is a store (rt is its data) |
| ex_valid | input | 1 | Execute pipeline register holds a live instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | AW | Execute destination register |
| mem_valid | input | 1 | Memory pipeline register holds a live instruction |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_rd | input | AW | Memory destination register |
| mem_is_store | input | 1 | Memory instruction is a store |
| mem_st_rt | input | AW | Data register of the store in memory |
| wb_valid | input | 1 | Writeback pipeline register holds a live instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| wb_load | input | 1 | Writeback instruction is a load |
| wb_rd | input | AW | Writeback destination register |
| fwd_a | output | 2 | Forwarding select for the rs operand |
| fwd_b | output | 2 | Forwarding select for the rt operand |
| stall | output | 1 | Freeze fetch and decode this cycle |
| bubble | output | 1 | Clear the valid bit entering execute |
| st_bypass | output | 1 | Replace store data in memory with the writeback load value |

## Verification
Forwarding priority and the load-use stall can fall in the same cycle. A load in execute matches an operand that memory and writeback also match, so the select must still read 01 while `stall` rises. The store bypass and the load-use exemption can also coincide. A store in decode behind a load (rt only, no stall) is set up alongside an older store in memory behind a load in writeback. The bench expects `stall`=0 and `st_bypass`=1 together. Each such cycle is judged against a reference model written in the bench from the requirements, and a long pseudo-random sweep over a small register range packs many such collisions.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSTAGE = 3;  // execute, memory, writeback
  localparam int ST_EX  = 0;
  localparam int ST_MEM = 1;
  localparam int ST_WB  = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10,
    FWD_WB  = 2'b11
  } fwd_sel_e;

  // nearest pending stage wins; index 0 is nearest
  function automatic fwd_sel_e nearest_sel(input logic [NSTAGE-1:0] hit);
    fwd_sel_e s;
    s = FWD_RF;
    for (int i = NSTAGE - 1; i >= 0; i--)
      if (hit[i]) s = fwd_sel_e'(i + 1);
    return s;
  endfunction
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int AW  = 5,
  parameter int NST = 3
) (
  input  logic [AW-1:0]          src,
  input  logic [NST-1:0]         live,
  input  logic [NST-1:0][AW-1:0] dst,
  output logic [NST-1:0]         hit
);
  logic src_nz;
  assign src_nz = (src != '0);

  for (genvar g = 0; g < NST; g++) begin : g_cmp
    assign hit[g] = live[g] && src_nz && (dst[g] == src);
  end

  always_comb begin
    assert_zero_never_hits_R5 : assert (src_nz || hit == '0)
      else $error("register 0 produced a match");
  end
endmodule

// File: rtl/hz_pick.sv
module hz_pick
  import hz_pkg::*;
(
  input  logic [NSTAGE-1:0] hit,
  output logic [1:0]        sel
);
  fwd_sel_e s;
  always_comb s = nearest_sel(hit);
  assign sel = s;

  always_comb begin
    assert_nearest_first_R3 : assert (!hit[ST_EX] || sel == FWD_EX)
      else $error("execute match not selected");
    assert_no_hit_rf_R2 : assert (hit != '0 || sel == FWD_RF)
      else $error("forward select without a match");
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse (
  input  logic ex_is_load,
  input  logic hit_rs_ex,
  input  logic hit_rt_ex,
  input  logic dec_is_store,
  output logic stall,
  output logic bubble
);
  logic rt_needs_wait;
  logic need_wait;

  // a store's data can be patched in memory, so rt alone does not wait
  assign rt_needs_wait = hit_rt_ex && !dec_is_store;
  assign need_wait     = ex_is_load && (hit_rs_ex || rt_needs_wait);
  assign stall         = need_wait;
  assign bubble        = need_wait;

  always_comb begin
    assert_store_rt_exempt_R7 : assert (!(dec_is_store && !hit_rs_ex) || !stall)
      else $error("store data dependency stalled");
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_is_store,
  input  logic          ex_valid,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_rd,
  input  logic          mem_valid,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_is_store,
  input  logic [AW-1:0] mem_st_rt,
  input  logic          wb_valid,
  input  logic          wb_we,
  input  logic          wb_load,
  input  logic [AW-1:0] wb_rd,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble,
  output logic          st_bypass
);
  localparam int NOPS = 2;

  logic [NSTAGE-1:0]         live;
  logic [NSTAGE-1:0][AW-1:0] dst;
  logic [NOPS-1:0][AW-1:0]   src;
  logic [NOPS-1:0][NSTAGE-1:0] hit;
  logic [NOPS-1:0][1:0]      sel;
  logic                      st_live;
  logic [0:0]                st_hit;

  // a stage is a pending write only while valid and writing
  assign live[ST_EX]  = ex_valid  && ex_we;
  assign live[ST_MEM] = mem_valid && mem_we;
  assign live[ST_WB]  = wb_valid  && wb_we;
  assign dst[ST_EX]   = ex_rd;
  assign dst[ST_MEM]  = mem_rd;
  assign dst[ST_WB]   = wb_rd;
  assign src[0]       = dec_rs;
  assign src[1]       = dec_rt;

  for (genvar op = 0; op < NOPS; op++) begin : g_op
    hz_match #(.AW(AW), .NST(NSTAGE)) u_match (
      .src (src[op]),
      .live(live),
      .dst (dst),
      .hit (hit[op])
    );
    hz_pick u_pick (
      .hit(hit[op]),
      .sel(sel[op])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hz_loaduse u_lu (
    .ex_is_load  (ex_load),
    .hit_rs_ex   (hit[0][ST_EX]),
    .hit_rt_ex   (hit[1][ST_EX]),
    .dec_is_store(dec_is_store),
    .stall       (stall),
    .bubble      (bubble)
  );

  // memory-stage store data patched from the load now in writeback
  assign st_live = mem_valid && mem_is_store && wb_valid && wb_we && wb_load;

  hz_match #(.AW(AW), .NST(1)) u_st_match (
    .src (mem_st_rt),
    .live(st_live),
    .dst (wb_rd),
    .hit (st_hit)
  );
  assign st_bypass = st_hit[0];

  always_comb begin
    assert_stall_needs_load_R6 : assert (!stall || (ex_valid && ex_load && ex_we))
      else $error("stall without a live load in execute");
    assert_invalid_ex_silent_R4 : assert (ex_valid || (fwd_a != FWD_EX && fwd_b != FWD_EX && !stall))
      else $error("invalid execute stage acted on");
    assert_wb_sel_live_R1 : assert (fwd_a != FWD_WB || (wb_valid && wb_we && wb_rd == dec_rs))
      else $error("writeback select without pending write");
    assert_bypass_src_R8 : assert (!st_bypass || (wb_load && mem_is_store && mem_st_rt != '0))
      else $error("store bypass without load feeding store");
  end
endmodule

// File: tb/hz_ctrl_test.sv
module hz_ctrl_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 4 ns period

  logic [AW-1:0] dec_rs, dec_rt, ex_rd, mem_rd, mem_st_rt, wb_rd;
  logic dec_is_store, ex_valid, ex_we, ex_load, mem_valid, mem_we, mem_is_store;
  logic wb_valid, wb_we, wb_load;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble, st_bypass;

  int n_chk = 0;
  int n_bad = 0;

  hz_ctrl #(.AW(AW)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_rs = 0; dec_rt = 0; dec_is_store = 0;
    ex_valid = 0; ex_we = 0; ex_load = 0; ex_rd = 0;
    mem_valid = 0; mem_we = 0; mem_rd = 0; mem_is_store = 0; mem_st_rt = 0;
    wb_valid = 0; wb_we = 0; wb_load = 0; wb_rd = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  // reference select from the requirements (R1..R5)
  function automatic int ref_sel(input logic [AW-1:0] s);
    if (s == 0) return 0;
    if (ex_valid && ex_we && ex_rd == s) return 1;
    if (mem_valid && mem_we && mem_rd == s) return 2;
    if (wb_valid && wb_we && wb_rd == s) return 3;
    return 0;
  endfunction

  function automatic int ref_stall();
    logic ld;
    ld = ex_valid && ex_we && ex_load;
    if (!ld) return 0;
    if (dec_rs != 0 && ex_rd == dec_rs) return 1;
    if (dec_rt != 0 && ex_rd == dec_rt && !dec_is_store) return 1;
    return 0;
  endfunction

  function automatic int ref_byp();
    return (mem_valid && mem_is_store && wb_valid && wb_we && wb_load &&
            mem_st_rt != 0 && wb_rd == mem_st_rt) ? 1 : 0;
  endfunction

  task automatic t_reset();
    idle(); settle();
    check("R2 idle fwd_a", fwd_a, 0);
    check("R2 idle fwd_b", fwd_b, 0);
    check("R6 idle stall", stall, 0);
    check("R8 idle bypass", st_bypass, 0);
  endtask

  task automatic t_single();
    idle();
    dec_rs = 3; dec_rt = 7;
    ex_valid = 1; ex_we = 1; ex_rd = 3;
    wb_valid = 1; wb_we = 1; wb_rd = 7;
    settle();
    check("R2 rs from execute", fwd_a, 1);
    check("R2 rt from writeback", fwd_b, 3);
    mem_valid = 1; mem_we = 1; mem_rd = 7; ex_rd = 9;
    settle();
    check("R2 rs none", fwd_a, 0);
    check("R3 rt memory over writeback", fwd_b, 2);
    check("R9 same-cycle", stall, 0);
  endtask

  task automatic t_priority();
    idle();
    dec_rs = 12; dec_rt = 12;
    ex_valid = 1; ex_we = 1; ex_rd = 12;
    mem_valid = 1; mem_we = 1; mem_rd = 12;
    wb_valid = 1; wb_we = 1; wb_rd = 12;
    settle();
    check("R3 all match rs", fwd_a, 1);
    check("R3 all match rt", fwd_b, 1);
  endtask

  task automatic t_qualify();
    idle();
    dec_rs = 5; dec_rt = 5;
    ex_valid = 0; ex_we = 1; ex_load = 1; ex_rd = 5;
    mem_valid = 1; mem_we = 0; mem_rd = 5;
    wb_valid = 0; wb_we = 1; wb_rd = 5;
    settle();
    check("R4 invalid ex ignored", fwd_a, 0);
    check("R4 invalid load no stall", stall, 0);
    check("R1 we=0 memory ignored", fwd_b, 0);
    ex_valid = 1; ex_we = 0;
    settle();
    check("R1 load without we no stall", stall, 0);
  endtask

  task automatic t_zero();
    idle();
    dec_rs = 0; dec_rt = 0;
    ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 0;
    mem_valid = 1; mem_we = 1; mem_rd = 0;
    settle();
    check("R5 r0 no forward", fwd_a, 0);
    check("R5 r0 no stall", stall, 0);
  endtask

  task automatic t_loaduse();
    idle();
    dec_rs = 8; dec_rt = 2;
    ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 2;
    mem_valid = 1; mem_we = 1; mem_rd = 2;
    settle();
    check("R6 rt load-use stall", stall, 1);
    check("R6 bubble", bubble, 1);
    check("R3 ex still selected during stall", fwd_b, 1);
    ex_rd = 8;
    settle();
    check("R6 rs load-use stall", stall, 1);
    ex_load = 0;
    settle();
    check("R6 no load no stall", stall, 0);
    check("R6 no load no bubble", bubble, 0);
  endtask

  task automatic t_store();
    idle();
    dec_is_store = 1; dec_rs = 4; dec_rt = 6;
    ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 6;
    mem_valid = 1; mem_is_store = 1; mem_st_rt = 9;
    wb_valid = 1; wb_we = 1; wb_load = 1; wb_rd = 9;
    settle();
    check("R7 store data exempt", stall, 0);
    check("R8 bypass with exempt store", st_bypass, 1);
    ex_rd = 4;
    settle();
    check("R7 store address stalls", stall, 1);
    mem_st_rt = 10;
    settle();
    check("R8 mismatch no bypass", st_bypass, 0);
    mem_st_rt = 9; wb_load = 0;
    settle();
    check("R8 non-load no bypass", st_bypass, 0);
    wb_load = 1; wb_valid = 0;
    settle();
    check("R4 invalid wb no bypass", st_bypass, 0);
    wb_valid = 1; mem_st_rt = 0; wb_rd = 0;
    settle();
    check("R8 r0 no bypass", st_bypass, 0);
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1234_5678;
    int bad0;
    bad0 = n_bad;
    for (int i = 0; i < 600; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      dec_rs = AW'(x[1:0]); dec_rt = AW'(x[3:2]); dec_is_store = x[4];
      ex_valid = x[5]; ex_we = x[6]; ex_load = x[7]; ex_rd = AW'(x[9:8]);
      mem_valid = x[10]; mem_we = x[11]; mem_rd = AW'(x[13:12]);
      mem_is_store = x[14]; mem_st_rt = AW'(x[16:15]);
      wb_valid = x[17]; wb_we = x[18]; wb_load = x[19]; wb_rd = AW'(x[21:20]);
      settle();
      check("R3 sweep fwd_a", fwd_a, ref_sel(dec_rs));
      check("R3 sweep fwd_b", fwd_b, ref_sel(dec_rt));
      check("R6 sweep stall", stall, ref_stall());
      check("R6 sweep bubble", bubble, ref_stall());
      check("R8 sweep bypass", st_bypass, ref_byp());
      if (n_bad - bad0 > 10) break;
    end
  endtask

  initial begin
    fork
      begin
        idle();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_priority();
        t_qualify();
        t_zero();
        t_loaduse();
        t_store();
        t_sweep();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule